// File: doc/BRIEF.md
# Display pixel data formatter

This block sits between a memory fetch engine and a parallel display bus. Each 32-bit word it receives is first byte-reordered by a selectable swizzle, then split into one or more pixels according to a programmable input pixel format. Every pixel is widened to an internal 24-bit red/green/blue form with 8 bits per channel. The internal pixel then passes a second, independent swizzle and an optional left or right barrel shift. It is finally clipped to the selected bus width.

Configuration comes in on static inputs that are held constant while data flows. Both the word input and the pixel output use valid/ready handshakes. The block stalls without losing or repeating a pixel when the display side is not ready. A new word can be accepted in the same cycle that the last pixel of the current word moves to the output register.

Top module: `pf_formatter`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1.
- R2: The input swizzle applies to each accepted word. Code 0 leaves the word unchanged. Code 1 reverses the byte order (byte 0 with byte 3, byte 1 with byte 2). Code 2 exchanges the 16-bit halves. Code 3 exchanges the two bytes within each 16-bit half.
- R3: The output swizzle uses the same four codes. It acts on the 32-bit value {8'h00, R, G, B} (R in bits 23:16, B in bits 7:0), before the shift and the width clip.
- R4: With fmt_i=0 and alt16_i=0, each word carries two RGB565 pixels, bits 15:0 first and then bits 31:16. Red is in bits 15:11, green in 10:5 and blue in 4:0. Each channel widens to 8 bits by copying its top bits into the vacated low bits.
- R5: With fmt_i=0 and alt16_i=1, each 16-bit half is read as ARGB555: bit 15 is dropped, red is in 14:10, green in 9:5 and blue in 4:0. Each channel widens by copying its top 3 bits.
- R6: With fmt_i=2, each word carries one RGB666 pixel. It sits in bits 17:0 when hi18_i=0 and in bits 31:14 when hi18_i=1. Red is the top 6 bits of that field and blue the bottom 6. Each channel widens by copying its top 2 bits.
- R7: With fmt_i=3 and pack6_i=0, bits 23:0 of the word are the pixel unchanged. With pack6_i=1, only the low 6 bits of bytes 2, 1 and 0 are kept as R, G and B, and each is widened as in R6.
- R8: With fmt_i=1, each word yields four 8-bit values, byte 0 first. Each value appears in out_data_o[7:0] with the upper bits zero.
- R9: shamt_i (0 to 31) shifts the swizzled 32-bit value left when shr_i=0 and right when shr_i=1. Vacated bit positions fill with zeros.
- R10: bus_w_i selects the output width: 0 is 16 bits, 1 is 8 bits, 2 is 18 bits and 3 is 24 bits. out_data_o bits at or above that width are 0.
- R11: While out_valid_o=1 and out_ready_i=0, out_valid_o and out_data_o hold. Every pixel appears exactly once and in order, whatever the back-pressure pattern.
- R12: in_ready_o is 1 whenever no word is held. It is also 1 when the last pixel of the held word is transferred in the current cycle. With one pixel per word and out_ready_i held at 1, one word is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted when high with in_valid_i |
| in_word_i | input | 32 | Fetched word |
| fmt_i | input | 2 | Input pixel format code |
| alt16_i | input | 1 | ARGB555 interpretation for 16-bit input |
| hi18_i | input | 1 | 18-bit pixel in the upper bits of the word |
| pack6_i | input | 1 | 24-bit input carries 6 useful bits per byte |
| in_swz_i | input | 2 | Input swizzle code |
| out_swz_i | input | 2 | Output swizzle code |
| shamt_i | input | 5 | Shift amount |
| shr_i | input | 1 | Shift direction, 1 = right |
| bus_w_i | input | 2 | Output bus width code |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Display side ready |
| out_data_o | output | 24 | Output pixel on the bus |

## Verification
Two things can fall in the same cycle. The last pixel of a held word can move into the output register while the next word is captured into the unpack register. The output register can also be drained and refilled in the same cycle. The bench provokes both by streaming back-to-back words in 16-bit mode under an irregular ready pattern, and by streaming one-pixel words with ready held high. It then judges the ordered list of delivered pixels against hand-computed values: no pixel may be missing or duplicated, and in the one-pixel case no input stall may occur.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int WORD_W = 32;
  localparam int PIX_W  = 24;

  typedef enum logic [1:0] {FMT_16 = 2'd0, FMT_8 = 2'd1, FMT_18 = 2'd2, FMT_24 = 2'd3} pix_fmt_e;
  typedef enum logic [1:0] {SWZ_NONE = 2'd0, SWZ_REV = 2'd1, SWZ_HALF = 2'd2, SWZ_BYTE = 2'd3} swz_e;

  function automatic logic [7:0] widen5(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] c);
    return {c, c[5:4]};
  endfunction

  function automatic int bus_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 8;
      2'd2:    return 18;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/pf_swizzle.sv
module pf_swizzle #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] data_i,
  input  logic [1:0]        mode_i,
  output logic [WORD_W-1:0] data_o
);
  import pf_pkg::*;
  localparam int NB = WORD_W / 8;
  localparam int HB = NB / 2;

  always_comb begin
    data_o = data_i;
    for (int b = 0; b < NB; b++) begin
      case (swz_e'(mode_i))
        SWZ_REV:  data_o[b*8 +: 8] = data_i[(NB-1-b)*8 +: 8];
        SWZ_HALF: data_o[b*8 +: 8] = data_i[((b+HB)%NB)*8 +: 8];
        SWZ_BYTE: data_o[b*8 +: 8] = data_i[(b^1)*8 +: 8];
        default:  data_o[b*8 +: 8] = data_i[b*8 +: 8];
      endcase
    end
  end
endmodule

// File: rtl/pf_unpack.sv
module pf_unpack #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] word_i,
  input  logic [1:0]        fmt_i,
  input  logic              alt16_i,
  input  logic              hi18_i,
  input  logic              pack6_i,
  output logic              pix_valid_o,
  output logic [PIX_W-1:0]  pix_o,
  input  logic              slot_free_i,
  output logic              held_o
);
  import pf_pkg::*;

  logic [WORD_W-1:0] word_q;
  logic [1:0]        idx_q;
  logic              held_q;
  logic [1:0]        last_idx;
  logic              take, last;
  logic [15:0]       half;
  logic [17:0]       d18;

  always_comb begin
    case (pix_fmt_e'(fmt_i))
      FMT_16:  last_idx = 2'd1;
      FMT_8:   last_idx = 2'd3;
      default: last_idx = 2'd0;
    endcase
  end

  assign last        = (idx_q == last_idx);
  assign take        = held_q && slot_free_i;
  assign in_ready_o  = !held_q || (take && last);
  assign pix_valid_o = held_q;
  assign held_o      = held_q;
  assign half        = idx_q[0] ? word_q[31:16] : word_q[15:0];
  assign d18         = hi18_i ? word_q[31:14] : word_q[17:0];

  always_comb begin
    case (pix_fmt_e'(fmt_i))
      FMT_8:   pix_o = {16'h0, word_q[{idx_q, 3'b000} +: 8]};
      FMT_16:  pix_o = alt16_i ? {widen5(half[14:10]), widen5(half[9:5]), widen5(half[4:0])}
                                : {widen5(half[15:11]), widen6(half[10:5]), widen5(half[4:0])};
      FMT_18:  pix_o = {widen6(d18[17:12]), widen6(d18[11:6]), widen6(d18[5:0])};
      default: pix_o = pack6_i ? {widen6(word_q[21:16]), widen6(word_q[13:8]), widen6(word_q[5:0])}
                                : word_q[23:0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      idx_q  <= '0;
      held_q <= 1'b0;
    end else if (in_valid_i && in_ready_o) begin
      word_q <= word_i;
      idx_q  <= '0;
      held_q <= 1'b1;
    end else if (take) begin
      if (last) held_q <= 1'b0;
      else      idx_q  <= idx_q + 2'd1;
    end
  end
endmodule

// File: rtl/pf_outstage.sv
module pf_outstage #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 24,
  parameter int OUT_W  = 24,
  parameter int SH_W   = $clog2(WORD_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             slot_free_o,
  input  logic [1:0]       out_swz_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic             shr_i,
  input  logic [1:0]       bus_w_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [OUT_W-1:0] out_data_o
);
  import pf_pkg::*;
  localparam int PAD = WORD_W - PIX_W;

  logic [WORD_W-1:0] swz, shifted;
  logic [OUT_W-1:0]  mask, data_n;
  int                nbits;

  pf_swizzle #(.WORD_W(WORD_W)) u_swz_out (
    .data_i ({{PAD{1'b0}}, pix_i}),
    .mode_i (out_swz_i),
    .data_o (swz)
  );

  assign shifted = shr_i ? (swz >> shamt_i) : (swz << shamt_i);
  assign nbits   = bus_bits(bus_w_i);

  always_comb begin
    for (int b = 0; b < OUT_W; b++) mask[b] = (b < nbits);
  end

  assign data_n      = OUT_W'(shifted) & mask;
  assign slot_free_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (pix_valid_i && slot_free_o) begin
      out_valid_o <= 1'b1;
      out_data_o  <= data_n;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pf_formatter.sv
module pf_formatter #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 24,
  parameter int OUT_W  = 24,
  parameter int SH_W   = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_word_i,
  input  logic [1:0]        fmt_i,
  input  logic              alt16_i,
  input  logic              hi18_i,
  input  logic              pack6_i,
  input  logic [1:0]        in_swz_i,
  input  logic [1:0]        out_swz_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic              shr_i,
  input  logic [1:0]        bus_w_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [OUT_W-1:0]  out_data_o
);
  logic [WORD_W-1:0] word_swz;
  logic              pix_valid, slot_free, unpack_held;
  logic [PIX_W-1:0]  pix;

  pf_swizzle #(.WORD_W(WORD_W)) u_swz_in (
    .data_i (in_word_i),
    .mode_i (in_swz_i),
    .data_o (word_swz)
  );

  pf_unpack #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_unpack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .word_i      (word_swz),
    .fmt_i       (fmt_i),
    .alt16_i     (alt16_i),
    .hi18_i      (hi18_i),
    .pack6_i     (pack6_i),
    .pix_valid_o (pix_valid),
    .pix_o       (pix),
    .slot_free_i (slot_free),
    .held_o      (unpack_held)
  );

  pf_outstage #(.WORD_W(WORD_W), .PIX_W(PIX_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pix_valid_i (pix_valid),
    .pix_i       (pix),
    .slot_free_o (slot_free),
    .out_swz_i   (out_swz_i),
    .shamt_i     (shamt_i),
    .shr_i       (shr_i),
    .bus_w_i     (bus_w_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o)
  );
endmodule

// File: rtl/pf_formatter_chk.sv
module pf_formatter_chk #(
  parameter int OUT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [OUT_W-1:0] out_data_o,
  input logic [1:0]       bus_w_i,
  input logic             held_i
);
  a_r11_hold_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o);

  a_r11_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> $stable(out_data_o));

  a_r11_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(held_i));

  a_r12_empty_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !held_i |-> in_ready_o);

  a_r10_clip8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && bus_w_i == 2'd1 |-> out_data_o[OUT_W-1:8] == '0);

  a_r10_clip16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && bus_w_i == 2'd0 |-> out_data_o[OUT_W-1:16] == '0);

  a_r10_clip18: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && bus_w_i == 2'd2 |-> out_data_o[OUT_W-1:18] == '0);
endmodule

bind pf_formatter pf_formatter_chk #(.OUT_W(OUT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .bus_w_i     (bus_w_i),
  .held_i      (unpack_held)
);

// File: tb/tb_pf_formatter.sv
`timescale 1ns/1ps
module tb_pf_formatter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_word_i = '0;
  logic [1:0]  fmt_i = 2'd3;
  logic        alt16_i = 1'b0, hi18_i = 1'b0, pack6_i = 1'b0;
  logic [1:0]  in_swz_i = '0, out_swz_i = '0;
  logic [4:0]  shamt_i = '0;
  logic        shr_i = 1'b0;
  logic [1:0]  bus_w_i = 2'd3;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [23:0] out_data_o;

  int n_chk = 0, n_fail = 0, in_stalls = 0;
  logic [23:0] got[$];
  logic [31:0] stim[$];

  always #2.5 clk_i = ~clk_i;

  pf_formatter dut (.*);

  typedef struct packed {
    logic [1:0]  fmt; logic alt; logic hi; logic pk;
    logic [1:0]  si;  logic [1:0] so; logic [4:0] sh; logic dir; logic [1:0] bw;
    logic [31:0] w;   logic [23:0] exp; logic [7:0] req;
  } vec_t;

  localparam vec_t VECS [20] = '{
    '{2'd3,1'b0,1'b0,1'b0,2'd0,2'd0,5'd0, 1'b0,2'd3,32'h00123456,24'h123456,8'd7},  // R7 plain
    '{2'd3,1'b0,1'b0,1'b0,2'd1,2'd0,5'd0, 1'b0,2'd3,32'h56341200,24'h123456,8'd2},  // R2 reverse
    '{2'd3,1'b0,1'b0,1'b0,2'd2,2'd0,5'd0, 1'b0,2'd3,32'h34560012,24'h123456,8'd2},  // R2 halves
    '{2'd3,1'b0,1'b0,1'b0,2'd3,2'd0,5'd0, 1'b0,2'd3,32'h12005634,24'h123456,8'd2},  // R2 bytes in half
    '{2'd3,1'b0,1'b0,1'b0,2'd0,2'd3,5'd0, 1'b0,2'd3,32'h00123456,24'h005634,8'd3},  // R3
    '{2'd3,1'b0,1'b0,1'b0,2'd0,2'd2,5'd0, 1'b0,2'd3,32'h00123456,24'h560012,8'd3},  // R3
    '{2'd3,1'b0,1'b0,1'b0,2'd0,2'd0,5'd4, 1'b0,2'd3,32'h00123456,24'h234560,8'd9},  // R9 left
    '{2'd3,1'b0,1'b0,1'b0,2'd0,2'd0,5'd8, 1'b1,2'd3,32'h00123456,24'h001234,8'd9},  // R9 right
    '{2'd3,1'b0,1'b0,1'b0,2'd0,2'd0,5'd0, 1'b0,2'd0,32'h00123456,24'h003456,8'd10}, // R10 16b
    '{2'd3,1'b0,1'b0,1'b0,2'd0,2'd0,5'd0, 1'b0,2'd1,32'h00123456,24'h000056,8'd10}, // R10 8b
    '{2'd3,1'b0,1'b0,1'b0,2'd0,2'd0,5'd0, 1'b0,2'd2,32'h00123456,24'h023456,8'd10}, // R10 18b
    '{2'd3,1'b0,1'b0,1'b1,2'd0,2'd0,5'd0, 1'b0,2'd3,32'h00FF40C1,24'hFF0004,8'd7},  // R7 pack6
    '{2'd2,1'b0,1'b0,1'b0,2'd0,2'd0,5'd0, 1'b0,2'd3,32'h0003F000,24'hFF0000,8'd6},  // R6 low
    '{2'd2,1'b0,1'b1,1'b0,2'd0,2'd0,5'd0, 1'b0,2'd3,32'h0003F000,24'h00003C,8'd6},  // R6 high
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,5'd0, 1'b0,2'd3,32'h07E0F800,24'hFF0000,8'd4},  // R4 red
    '{2'd0,1'b1,1'b0,1'b0,2'd0,2'd0,5'd0, 1'b0,2'd3,32'h0000FC00,24'hFF0000,8'd5},  // R5 alpha dropped
    '{2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,5'd0, 1'b0,2'd3,32'h00000010,24'h000084,8'd4},  // R4 widen
    '{2'd1,1'b0,1'b0,1'b0,2'd0,2'd0,5'd0, 1'b0,2'd3,32'hDDCCBBAA,24'h0000AA,8'd8},  // R8
    '{2'd3,1'b0,1'b0,1'b0,2'd0,2'd0,5'd31,1'b0,2'd3,32'h00000001,24'h000000,8'd9},  // R9 max left
    '{2'd3,1'b0,1'b0,1'b0,2'd0,2'd0,5'd20,1'b1,2'd3,32'h00FFFFFF,24'h00000F,8'd9}   // R9 right 20
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid_i = 1'b0;
    out_ready_i = 1'b1;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic run_stream(input int nexp, input logic [31:0] rpat);
    int wi = 0;
    int cn = 0;
    got.delete();
    in_stalls = 0;
    while ((wi < stim.size() || got.size() < nexp) && cn < 1000) begin
      in_valid_i  = (wi < stim.size());
      in_word_i   = (wi < stim.size()) ? stim[wi] : 32'h0;
      out_ready_i = rpat[cn % 32];
      #1;
      if (in_valid_i && !in_ready_o) in_stalls++;
      if (in_valid_i && in_ready_o) wi++;
      if (out_valid_o && out_ready_i) got.push_back(out_data_o);
      @(negedge clk_i);
      cn++;
    end
    in_valid_i  = 1'b0;
    out_ready_i = 1'b1;
    repeat (6) begin
      #1;
      if (out_valid_o && out_ready_i) got.push_back(out_data_o);
      @(negedge clk_i);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 out_valid", {31'h0, out_valid_o}, 32'h0);
    check("R1 in_ready",  {31'h0, in_ready_o},  32'h1);

    foreach (VECS[i]) begin
      do_reset();
      fmt_i = VECS[i].fmt; alt16_i = VECS[i].alt; hi18_i = VECS[i].hi; pack6_i = VECS[i].pk;
      in_swz_i = VECS[i].si; out_swz_i = VECS[i].so; shamt_i = VECS[i].sh;
      shr_i = VECS[i].dir; bus_w_i = VECS[i].bw;
      stim.delete();
      stim.push_back(VECS[i].w);
      run_stream(1, 32'hFFFF_FFFF);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            (got.size() > 0) ? {8'h0, got[0]} : 32'hDEAD_BEEF, {8'h0, VECS[i].exp});
    end

    // R8 byte order, four values per word
    do_reset();
    fmt_i = 2'd1; in_swz_i = '0; out_swz_i = '0; shamt_i = '0; shr_i = 1'b0; bus_w_i = 2'd3;
    alt16_i = 1'b0; hi18_i = 1'b0; pack6_i = 1'b0;
    stim.delete();
    stim.push_back(32'hDDCCBBAA);
    run_stream(4, 32'hFFFF_FFFF);
    check("R8 count", got.size(), 4);
    if (got.size() == 4) begin
      check("R8 byte0", {8'h0, got[0]}, 32'hAA);
      check("R8 byte1", {8'h0, got[1]}, 32'hBB);
      check("R8 byte2", {8'h0, got[2]}, 32'hCC);
      check("R8 byte3", {8'h0, got[3]}, 32'hDD);
    end

    // R11 / R4: back-to-back 16-bit words under irregular back-pressure
    do_reset();
    fmt_i = 2'd0;
    stim.delete();
    stim.push_back(32'h07E0F800);
    stim.push_back(32'h001F0010);
    run_stream(4, 32'b1001_0110_0011_0100_1101_0010_0001_1010);
    check("R11 count", got.size(), 4);
    if (got.size() == 4) begin
      check("R4 pix0", {8'h0, got[0]}, 32'hFF0000);
      check("R4 pix1", {8'h0, got[1]}, 32'h00FF00);
      check("R11 pix2", {8'h0, got[2]}, 32'h000084);
      check("R11 pix3", {8'h0, got[3]}, 32'h0000FF);
    end

    // R12: one pixel per word, full throughput
    do_reset();
    fmt_i = 2'd3;
    stim.delete();
    stim.push_back(32'h11);
    stim.push_back(32'h22);
    stim.push_back(32'h33);
    run_stream(3, 32'hFFFF_FFFF);
    check("R12 no input stall", in_stalls, 0);
    check("R12 count", got.size(), 3);
    if (got.size() == 3) begin
      check("R12 order0", {8'h0, got[0]}, 32'h11);
      check("R12 order2", {8'h0, got[2]}, 32'h33);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule